// File: doc/BRIEF.md
# Keypad Status Register with Opposing-Direction Filter

The block captures the state of ten push buttons and presents it to software as an active-low status word. A button that is held reads as 0 and a released button reads as 1. With no button held, the ten key bits read as all ones (0x03FF). The upper six bits of the 16-bit word always read as 0.

The key vector is captured only when the read strobe is asserted. The captured value then stays on the read data output until the next strobe. Every read therefore returns one coherent snapshot, even if the buttons change while it is in progress.

A filter can be switched on to remove direction combinations that a real pad cannot produce. When left and right are held together, both are reported as released. The same applies to up and down held together. A replay source can take the place of the live buttons; while it is selected, the filter does not act.

A logging port lets an external recorder capture each live sample. It gives a one-cycle valid pulse together with the filtered held-key vector (active high). Replayed reads are not logged.

Top module: `keypad_status_reg`

## Requirements
- R1: After reset, rd_data reads 0x03FF and log_valid is 0.
- R2: rd_data[15:10] always reads 0.
- R3: The cycle after rd_stb is sampled high, rd_data[9:0] equals the held-key vector XOR 0x3FF. Bit i is 0 when key i is held.
- R4: When rd_stb is low, rd_data keeps its value, whatever the key, filter or replay inputs do.
- R5: With the filter on and replay off, if keys 4 and 5 (the right/left pair) are both held, both read as 1. If only one of them is held, it reads as 0.
- R6: With the filter on and replay off, if keys 6 and 7 (the up/down pair) are both held, both read as 1. If only one of them is held, it reads as 0.
- R7: Key bits 0 to 3, 8 and 9 are never changed by the filter.
- R8: While replay_active is high at the strobe, replay_keys is used in place of keys_held and the filter is bypassed.
- R9: log_valid pulses high for one cycle, in the cycle after each strobe taken with replay off. In that cycle log_keys equals the filtered held-key vector (active high). A strobe taken with replay on gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| keys_held | input | 10 | Live buttons, 1 = held |
| opp_filter_en | input | 1 | Enables opposing-direction suppression |
| replay_active | input | 1 | Selects replay_keys as the source |
| replay_keys | input | 10 | Replayed buttons, 1 = held |
| rd_stb | input | 1 | Read strobe; captures a snapshot |
| rd_data | output | 16 | Active-low status word |
| log_valid | output | 1 | One-cycle pulse marking a logged sample |
| log_keys | output | 10 | Logged held-key vector, 1 = held |

## Verification
The assertions assume that the inputs are synchronous to clk and stable around the rising edge. They also assume that the filter and replay controls are valid in the same cycle as rd_stb, because that is the cycle in which they are sampled. The stimulus changes every input only on the falling edge. It mixes held-key patterns with the filter and replay settings, sometimes with back-to-back strobes and sometimes with idle cycles in which the keys keep changing.

// File: rtl/keypad_status_reg.sv
module keypad_status_reg #(
  parameter int KEYS   = 10,
  parameter int DATA_W = 16,
  parameter int LR_LO  = 4,
  parameter int UD_LO  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [KEYS-1:0]   keys_held,
  input  logic              opp_filter_en,
  input  logic              replay_active,
  input  logic [KEYS-1:0]   replay_keys,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              log_valid,
  output logic [KEYS-1:0]   log_keys
);

  localparam logic [KEYS-1:0] ALL_UP = '1;

  logic [KEYS-1:0] src, drop, filt, snap;
  logic            filt_on, lr_both, ud_both;

  assign src     = replay_active ? replay_keys : keys_held;
  assign filt_on = opp_filter_en & ~replay_active;
  assign lr_both = filt_on & src[LR_LO] & src[LR_LO+1];
  assign ud_both = filt_on & src[UD_LO] & src[UD_LO+1];

  always_comb begin
    drop = '0;
    drop[LR_LO +: 2] = {2{lr_both}};
    drop[UD_LO +: 2] = {2{ud_both}};
  end

  assign filt = src & ~drop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap      <= '0;
      log_valid <= 1'b0;
    end else begin
      log_valid <= rd_stb & ~replay_active;
      if (rd_stb) snap <= filt;
    end
  end

  assign rd_data  = {{(DATA_W-KEYS){1'b0}}, snap ^ ALL_UP};
  assign log_keys = snap;

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:KEYS] == '0);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));

  p_no_lr_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && opp_filter_en && !replay_active) |=> rd_data[LR_LO +: 2] != 2'b00);

  p_no_ud_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && opp_filter_en && !replay_active) |=> rd_data[UD_LO +: 2] != 2'b00);

  p_log_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !replay_active) |=> log_valid);

  p_no_log_replay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && replay_active) |=> !log_valid);

  p_log_only_after_stb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !log_valid);

endmodule

// File: tb/keypad_status_reg_tb_top.sv
module keypad_status_reg_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [9:0]  keys_held = 0, replay_keys = 0;
  logic        opp_filter_en = 0, replay_active = 0, rd_stb = 0;
  logic [15:0] rd_data;
  logic        log_valid;
  logic [9:0]  log_keys;

  keypad_status_reg dut_i (
    .clk(clk), .rst_n(rst_n), .keys_held(keys_held), .opp_filter_en(opp_filter_en),
    .replay_active(replay_active), .replay_keys(replay_keys), .rd_stb(rd_stb),
    .rd_data(rd_data), .log_valid(log_valid), .log_keys(log_keys));

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_vec = 0, n_bad = 0;
  string cur_req = "R1";
  bit    finished = 0;

  int         m_snap = 0;
  bit         m_lv = 0;

  function automatic int ref_value(int k, bit f, bit rep, int rk);
    int v;
    v = rep ? rk : k;
    if (f && !rep) begin
      if (((v >> 4) & 3) == 3) v = v & ~32'h30;
      if (((v >> 6) & 3) == 3) v = v & ~32'hC0;
    end
    return v & 32'h3FF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_snap <= 0;
      m_lv   <= 0;
    end else begin
      m_lv <= rd_stb && !replay_active;
      if (rd_stb) m_snap <= ref_value(keys_held, opp_filter_en, replay_active, replay_keys);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_vec++;
      if (rd_data !== 16'((m_snap ^ 32'h3FF))) begin
        n_bad++;
        $display("FAIL %s rd_data actual=%h expected=%h", cur_req, rd_data, 16'(m_snap ^ 32'h3FF));
      end
      if (log_valid !== m_lv) begin
        n_bad++;
        $display("FAIL %s log_valid actual=%b expected=%b", cur_req, log_valid, m_lv);
      end
      if (m_lv && log_keys !== 10'(m_snap)) begin
        n_bad++;
        $display("FAIL %s log_keys actual=%h expected=%h", cur_req, log_keys, 10'(m_snap));
      end
    end
  end

  task automatic step(input logic [9:0] k, input bit f, input bit rep,
                      input logic [9:0] rk, input bit stb);
    @(negedge clk);
    keys_held = k; opp_filter_en = f; replay_active = rep; replay_keys = rk; rd_stb = stb;
  endtask

  task automatic rd(input logic [9:0] k, input bit f);
    step(k, f, 0, 10'h0, 1);
  endtask

  initial begin
    int lfsr = 32'h1ACE;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    cur_req = "R3";
    rd(10'h001, 0); rd(10'h200, 0); rd(10'h3FF, 0); rd(10'h155, 0); rd(10'h0F0, 0);
    step(0, 0, 0, 0, 0);
    cur_req = "R4";
    rd(10'h2AA, 0);
    step(10'h3FF, 1, 1, 10'h3FF, 0);
    step(10'h000, 0, 0, 10'h000, 0);
    step(10'h123, 1, 0, 10'h000, 0);
    cur_req = "R5";
    rd(10'h030, 1); rd(10'h010, 1); rd(10'h020, 1); rd(10'h030, 0);
    cur_req = "R6";
    rd(10'h0C0, 1); rd(10'h040, 1); rd(10'h080, 1); rd(10'h0F0, 1); rd(10'h0C0, 0);
    cur_req = "R7";
    rd(10'h3FF, 1); rd(10'h30F, 1); rd(10'h33C, 1);
    cur_req = "R8";
    step(10'h001, 1, 1, 10'h0F0, 1);
    step(10'h3FF, 1, 1, 10'h030, 1);
    step(10'h000, 0, 1, 10'h3C3, 1);
    step(10'h000, 0, 0, 10'h000, 0);
    cur_req = "R9";
    rd(10'h0B1, 1);
    step(0, 0, 0, 0, 0);
    rd(10'h0F3, 1);
    step(10'h0FF, 1, 1, 10'h00F, 1);
    rd(10'h3FF, 1);
    cur_req = "R2";
    for (int i = 0; i < 400; i++) begin
      lfsr = (lfsr << 1) ^ (((lfsr >> 31) ^ (lfsr >> 21) ^ (lfsr >> 1) ^ lfsr) & 1);
      step(10'(lfsr), lfsr[12], lfsr[13] & lfsr[14], 10'(lfsr >> 16), lfsr[15]);
    end
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog %s actual=timeout expected=completion", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule